// File: doc/BRIEF.md
# Split-Ring Descriptor Chain Fetcher

This block pulls work items out of a split virtqueue that lives in host memory. Software configures the queue with a page number and a ring size given as a power of two. From these two values the block derives three base addresses: the descriptor table, the ring of offered entries (the "available ring") and the completion ring (the "used ring"). It also keeps its own running index of the next offered entry that it has not yet taken.

A command asks for one of three actions. GET takes the next offered entry. PEEK looks at that entry without taking it. SKIP takes the entry without walking it. For GET and PEEK, the block reads the offered slot to obtain the head descriptor index. It then follows the linked descriptor chain through a request/response memory read port and emits one segment record per descriptor. Each record carries an address, a length and a direction. A completion pulse ends every command. It reports whether an entry was found, the head index, how many device-writable and device-readable segments were seen, and whether the chain was cut off as malformed.

Moving payload data and writing completions belong to other blocks. This one only reads.

Top module: `vq_chain_fetch`

## Requirements
- R1: The descriptor table base equals the configured page number shifted left by PAGE_SHIFT (default 12, so 4096-byte pages).
- R2: The available ring base is the descriptor table base plus 16 bytes times the ring size. The used ring base is the end of the available ring rounded up to the next page boundary. The available ring is a 2-byte flags word, a 2-byte index, then 2 bytes per entry.
- R3: Reset, or a configuration write with page number 0, clears all three bases, the page number and the next-available index. A configuration write with a non-zero page number loads the new bases and sets the next-available index to 0.
- R4: Every command first reads the 16-bit guest index at available base + 2. If it equals the next-available index, the queue is empty: the command completes with done_ok=0 and done_err=0, no segments are emitted, both counts are 0, and the next-available index is unchanged.
- R5: GET (cmd_op=0) on a non-empty queue reads the 16-bit entry at available base + 4 + 2×(next-available mod size). It reports that entry as done_head and advances the next-available index by one.
- R6: PEEK (cmd_op=1, and also the spare code 3) behaves like GET but leaves the next-available index unchanged.
- R7: SKIP (cmd_op=2) on a non-empty queue only advances the next-available index. It completes with done_ok=1, emits no segment and reports head 0.
- R8: A descriptor sits at table base + 16×(index mod size). Its layout is little-endian: bytes 0–7 hold the address, bytes 8–11 the length, bytes 12–13 the flags, and bytes 14–15 the next index. Flag bit 1 set emits the segment with seg_write=1 and counts it in done_n_in; flag bit 1 clear emits seg_write=0 and counts it in done_n_out.
- R9: The walk follows the next field while flag bit 0 is set. It stops after the first descriptor with bit 0 clear and then reports done_ok=1.
- R10: If the descriptor at position number "size" in a chain still has bit 0 set, the walk stops after emitting it and reports done_err=1 and done_ok=0. The two counts then sum to the ring size.
- R11: The ring size is 2^cfg_size_log2. Slot and descriptor indices use only their low log2 bits, so head or next values at or above the size wrap.
- R12: The memory port has at most one read outstanding. A request keeps its valid and address steady until mem_req_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load queue configuration (only while cmd_ready) |
| cfg_pfn | input | PFN_W | Page number of the descriptor table; 0 clears the queue |
| cfg_size_log2 | input | LOG2_W | log2 of ring size |
| q_pfn | output | PFN_W | Stored page number |
| q_desc_base | output | ADDR_W | Descriptor table base |
| q_avail_base | output | ADDR_W | Available ring base |
| q_used_base | output | ADDR_W | Used ring base |
| q_next_avail | output | IDX_W | Next-available index |
| cmd_valid | input | 1 | Command strobe, taken when cmd_ready |
| cmd_op | input | 2 | 0 GET, 1 PEEK, 2 SKIP, 3 PEEK |
| cmd_ready | output | 1 | Idle, able to take a command |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of the read |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | RD_W | 16 bytes starting at the address, byte 0 in bits 7:0 |
| seg_valid | output | 1 | Segment record valid (one cycle) |
| seg_addr | output | 64 | Segment buffer address |
| seg_len | output | 32 | Segment length |
| seg_write | output | 1 | 1 = device writes the buffer |
| done_valid | output | 1 | Command complete (one cycle) |
| done_ok | output | 1 | Entry found and chain well formed |
| done_err | output | 1 | Chain longer than the ring |
| done_head | output | IDX_W | Head descriptor index of the entry |
| done_n_in | output | IDX_W | Device-writable segment count |
| done_n_out | output | IDX_W | Device-readable segment count |

## Verification
The bench targets the following corner cases; each entry names the fault a wrong design would show.
- Empty detection: a design that compared the wrong index would emit stale segments from an empty ring.
- PEEK versus GET: a design that advanced on PEEK would lose an entry.
- Index wrap: head values, next values and running indices at or above the ring size must wrap. A design without the modulo would fetch descriptors from outside the table.
- Self-looping chain: the walk must be cut at exactly ring-size descriptors. A design that was off by one, or never stopped, would show a wrong count or hang.
- Ready throttling: the random memory stall and ready pattern exposes any request that changes while it waits.

// File: rtl/vq_pkg.sv
// Shared encodings and memory layout constants for the split-ring fetcher.
package vq_pkg;
    typedef enum logic [1:0] {
        OP_GET  = 2'd0,
        OP_PEEK = 2'd1,
        OP_SKIP = 2'd2,
        OP_RSVD = 2'd3
    } vq_op_e;

    localparam int DESC_SHIFT     = 4;  // descriptor entry is 16 bytes
    localparam int AVAIL_IDX_OFS  = 2;  // guest index inside available ring
    localparam int AVAIL_RING_OFS = 4;  // first entry of the available ring
    localparam int FLAG_CHAIN     = 0;  // another descriptor follows
    localparam int FLAG_DEVWR     = 1;  // device writes this buffer

    // Little-endian 16-byte descriptor as it appears on the read port.
    typedef struct packed {
        logic [15:0] link;
        logic [15:0] flags;
        logic [31:0] len;
        logic [63:0] addr;
    } vq_desc_t;
endpackage

// File: rtl/vq_ring_layout.sv
// Ring address calculator.
// Derives the three ring bases from a page number and a power-of-two size.
// Assumes ADDR_W >= PFN_W + PAGE_SHIFT so that the shift loses no bits.
module vq_ring_layout
    import vq_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PFN_W      = 32,
    parameter int LOG2_W     = 4,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [PFN_W-1:0]  pfn,
    input  logic [LOG2_W-1:0] size_log2,
    output logic [ADDR_W-1:0] desc_base,
    output logic [ADDR_W-1:0] avail_base,
    output logic [ADDR_W-1:0] used_base
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

    logic [ADDR_W-1:0] entries;
    logic [ADDR_W-1:0] avail_end;

    // Purpose: page-aligned table, packed available ring, page-rounded used ring.
    always_comb begin
        entries    = ADDR_W'(1) << size_log2;
        desc_base  = ADDR_W'(pfn) << PAGE_SHIFT;
        avail_base = desc_base + (entries << DESC_SHIFT);
        avail_end  = avail_base + ADDR_W'(AVAIL_RING_OFS) + (entries << 1);
        used_base  = (avail_end + PAGE_MASK) & ~PAGE_MASK;
    end
endmodule

// File: rtl/vq_queue_regs.sv
// Queue configuration and running-index registers.
// Holds the page number, the ring size, the computed bases and the
// next-available index. A configuration write wins over an advance pulse.
// Assumes the configuration is written only while no command is in flight.
module vq_queue_regs #(
    parameter int ADDR_W     = 64,
    parameter int PFN_W      = 32,
    parameter int LOG2_W     = 4,
    parameter int IDX_W      = 16,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [PFN_W-1:0]  cfg_pfn,
    input  logic [LOG2_W-1:0] cfg_size_log2,
    input  logic [ADDR_W-1:0] calc_desc,
    input  logic [ADDR_W-1:0] calc_avail,
    input  logic [ADDR_W-1:0] calc_used,
    input  logic              adv,
    output logic [PFN_W-1:0]  pfn_q,
    output logic [LOG2_W-1:0] size_log2_q,
    output logic [ADDR_W-1:0] desc_q,
    output logic [ADDR_W-1:0] avail_q,
    output logic [ADDR_W-1:0] used_q,
    output logic [IDX_W-1:0]  next_avail
);
    // Purpose: load or clear the queue on a config write, else track advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pfn_q       <= '0;
            size_log2_q <= '0;
            desc_q      <= '0;
            avail_q     <= '0;
            used_q      <= '0;
            next_avail  <= '0;
        end else if (cfg_wr) begin
            size_log2_q <= cfg_size_log2;
            pfn_q       <= cfg_pfn;
            next_avail  <= '0;
            if (cfg_pfn == '0) begin
                desc_q  <= '0;
                avail_q <= '0;
                used_q  <= '0;
            end else begin
                desc_q  <= calc_desc;
                avail_q <= calc_avail;
                used_q  <= calc_used;
            end
        end else if (adv) begin
            next_avail <= next_avail + IDX_W'(1);
        end
    end

    assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !adv) |=> $stable(next_avail));

    assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !cfg_wr) |=> (next_avail == $past(next_avail) + IDX_W'(1)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_pfn == '0) |=> (pfn_q == '0 && desc_q == '0 && used_q == '0 && next_avail == '0));

    assert_used_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pfn_q != '0) |-> (used_q[PAGE_SHIFT-1:0] == '0 && used_q > avail_q && avail_q > desc_q));
endmodule

// File: rtl/vq_chain_walker.sv
// Command sequencer and descriptor chain walker.
// Reads the guest index, the offered slot and then each descriptor of the
// chain through a single-outstanding read port. Emits one segment record per
// descriptor and a completion pulse. Assumes mem_resp_valid only follows an
// accepted request and that the bases stay constant while a command runs.
module vq_chain_walker
    import vq_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LOG2_W = 4,
    parameter int IDX_W  = 16,
    parameter int RD_W   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [ADDR_W-1:0] avail_base,
    input  logic [LOG2_W-1:0] size_log2,
    input  logic [IDX_W-1:0]  next_avail,
    output logic              adv,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    output logic              cmd_ready,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [RD_W-1:0]   mem_resp_data,
    output logic              seg_valid,
    output logic [63:0]       seg_addr,
    output logic [31:0]       seg_len,
    output logic              seg_write,
    output logic              done_valid,
    output logic              done_ok,
    output logic              done_err,
    output logic [IDX_W-1:0]  done_head,
    output logic [IDX_W-1:0]  done_n_in,
    output logic [IDX_W-1:0]  done_n_out
);
    localparam int CNT_W = IDX_W + 1;

    typedef enum logic [2:0] {
        W_IDLE, W_IDX_REQ, W_IDX_WAIT, W_HEAD_REQ, W_HEAD_WAIT, W_DESC_REQ, W_DESC_WAIT
    } wstate_e;

    wstate_e           state;
    vq_op_e            op_q;
    logic [ADDR_W-1:0] req_addr;
    logic [CNT_W-1:0]  walked;
    logic [IDX_W-1:0]  n_in;
    logic [IDX_W-1:0]  n_out;

    logic [CNT_W-1:0]  ring_size;
    logic [IDX_W-1:0]  mask;
    vq_desc_t          dsc;
    logic [IDX_W-1:0]  resp16;
    logic              ring_empty;
    logic              dev_wr;
    logic              chained;
    logic [IDX_W-1:0]  in_nx;
    logic [IDX_W-1:0]  out_nx;
    logic [CNT_W-1:0]  walked_nx;
    logic [ADDR_W-1:0] slot_addr;
    logic [ADDR_W-1:0] head_addr;
    logic [ADDR_W-1:0] link_addr;

    // Purpose: decode the response word and form the next read addresses.
    always_comb begin
        ring_size  = CNT_W'(1) << size_log2;
        mask       = IDX_W'(ring_size - CNT_W'(1));
        dsc        = vq_desc_t'(mem_resp_data[127:0]);
        resp16     = mem_resp_data[IDX_W-1:0];
        ring_empty = (resp16 == next_avail);
        dev_wr     = dsc.flags[FLAG_DEVWR];
        chained    = dsc.flags[FLAG_CHAIN];
        in_nx      = n_in + IDX_W'(dev_wr);
        out_nx     = n_out + IDX_W'(!dev_wr);
        walked_nx  = walked + CNT_W'(1);
        slot_addr  = avail_base + ADDR_W'(AVAIL_RING_OFS) + (ADDR_W'(next_avail & mask) << 1);
        head_addr  = desc_base + (ADDR_W'(resp16 & mask) << DESC_SHIFT);
        link_addr  = desc_base + (ADDR_W'(dsc.link & mask) << DESC_SHIFT);
    end

    // Purpose: pulse the index advance when a SKIP or GET takes an entry.
    always_comb begin
        adv = 1'b0;
        if (mem_resp_valid) begin
            if (state == W_IDX_WAIT && !ring_empty && op_q == OP_SKIP) adv = 1'b1;
            if (state == W_HEAD_WAIT && op_q == OP_GET)                adv = 1'b1;
        end
    end

    assign cmd_ready     = (state == W_IDLE);
    assign mem_req_valid = (state == W_IDX_REQ) || (state == W_HEAD_REQ) || (state == W_DESC_REQ);
    assign mem_req_addr  = req_addr;
    assign done_n_in     = n_in;
    assign done_n_out    = n_out;

    // Purpose: command sequencing, chain walk and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= W_IDLE;
            op_q       <= OP_GET;
            req_addr   <= '0;
            walked     <= '0;
            n_in       <= '0;
            n_out      <= '0;
            seg_valid  <= 1'b0;
            seg_addr   <= '0;
            seg_len    <= '0;
            seg_write  <= 1'b0;
            done_valid <= 1'b0;
            done_ok    <= 1'b0;
            done_err   <= 1'b0;
            done_head  <= '0;
        end else begin
            seg_valid  <= 1'b0;
            done_valid <= 1'b0;
            case (state)
                W_IDLE: if (cmd_valid) begin
                    op_q      <= vq_op_e'(cmd_op);
                    req_addr  <= avail_base + ADDR_W'(AVAIL_IDX_OFS);
                    walked    <= '0;
                    n_in      <= '0;
                    n_out     <= '0;
                    done_head <= '0;
                    state     <= W_IDX_REQ;
                end
                W_IDX_REQ:  if (mem_req_ready) state <= W_IDX_WAIT;
                W_IDX_WAIT: if (mem_resp_valid) begin
                    if (ring_empty || op_q == OP_SKIP) begin
                        done_valid <= 1'b1;
                        done_ok    <= !ring_empty;
                        done_err   <= 1'b0;
                        state      <= W_IDLE;
                    end else begin
                        req_addr <= slot_addr;
                        state    <= W_HEAD_REQ;
                    end
                end
                W_HEAD_REQ:  if (mem_req_ready) state <= W_HEAD_WAIT;
                W_HEAD_WAIT: if (mem_resp_valid) begin
                    done_head <= resp16;
                    req_addr  <= head_addr;
                    state     <= W_DESC_REQ;
                end
                W_DESC_REQ:  if (mem_req_ready) state <= W_DESC_WAIT;
                W_DESC_WAIT: if (mem_resp_valid) begin
                    seg_valid <= 1'b1;
                    seg_addr  <= dsc.addr;
                    seg_len   <= dsc.len;
                    seg_write <= dev_wr;
                    n_in      <= in_nx;
                    n_out     <= out_nx;
                    walked    <= walked_nx;
                    if (chained && walked_nx != ring_size) begin
                        req_addr <= link_addr;
                        state    <= W_DESC_REQ;
                    end else begin
                        done_valid <= 1'b1;
                        done_ok    <= !chained;
                        done_err   <= chained;
                        state      <= W_IDLE;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_loop_cut_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_err) |-> ((CNT_W'(done_n_in) + CNT_W'(done_n_out)) == ring_size));

    assert_empty_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_ok && !done_err) |-> (done_n_in == '0 && done_n_out == '0));

    assert_seg_in_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (!cmd_ready || done_valid));
endmodule

// File: rtl/vq_chain_fetch.sv
// Split-ring descriptor chain fetcher, top level.
// Ties the address calculator, the queue registers and the chain walker
// together. Assumes RD_W is at least one descriptor (128 bits).
module vq_chain_fetch #(
    parameter int ADDR_W     = 64,
    parameter int PFN_W      = 32,
    parameter int LOG2_W     = 4,
    parameter int IDX_W      = 16,
    parameter int PAGE_SHIFT = 12,
    parameter int RD_W       = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [PFN_W-1:0]  cfg_pfn,
    input  logic [LOG2_W-1:0] cfg_size_log2,
    output logic [PFN_W-1:0]  q_pfn,
    output logic [ADDR_W-1:0] q_desc_base,
    output logic [ADDR_W-1:0] q_avail_base,
    output logic [ADDR_W-1:0] q_used_base,
    output logic [IDX_W-1:0]  q_next_avail,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    output logic              cmd_ready,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [RD_W-1:0]   mem_resp_data,
    output logic              seg_valid,
    output logic [63:0]       seg_addr,
    output logic [31:0]       seg_len,
    output logic              seg_write,
    output logic              done_valid,
    output logic              done_ok,
    output logic              done_err,
    output logic [IDX_W-1:0]  done_head,
    output logic [IDX_W-1:0]  done_n_in,
    output logic [IDX_W-1:0]  done_n_out
);
    logic [ADDR_W-1:0] calc_desc;
    logic [ADDR_W-1:0] calc_avail;
    logic [ADDR_W-1:0] calc_used;
    logic [LOG2_W-1:0] size_log2_q;
    logic              adv;

    vq_ring_layout #(
        .ADDR_W(ADDR_W), .PFN_W(PFN_W), .LOG2_W(LOG2_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) layout_i (
        .pfn        (cfg_pfn),
        .size_log2  (cfg_size_log2),
        .desc_base  (calc_desc),
        .avail_base (calc_avail),
        .used_base  (calc_used)
    );

    vq_queue_regs #(
        .ADDR_W(ADDR_W), .PFN_W(PFN_W), .LOG2_W(LOG2_W), .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr        (cfg_wr),
        .cfg_pfn       (cfg_pfn),
        .cfg_size_log2 (cfg_size_log2),
        .calc_desc     (calc_desc),
        .calc_avail    (calc_avail),
        .calc_used     (calc_used),
        .adv           (adv),
        .pfn_q         (q_pfn),
        .size_log2_q   (size_log2_q),
        .desc_q        (q_desc_base),
        .avail_q       (q_avail_base),
        .used_q        (q_used_base),
        .next_avail    (q_next_avail)
    );

    vq_chain_walker #(
        .ADDR_W(ADDR_W), .LOG2_W(LOG2_W), .IDX_W(IDX_W), .RD_W(RD_W)
    ) walker_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .desc_base      (q_desc_base),
        .avail_base     (q_avail_base),
        .size_log2      (size_log2_q),
        .next_avail     (q_next_avail),
        .adv            (adv),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_ready      (cmd_ready),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data),
        .seg_valid      (seg_valid),
        .seg_addr       (seg_addr),
        .seg_len        (seg_len),
        .seg_write      (seg_write),
        .done_valid     (done_valid),
        .done_ok        (done_ok),
        .done_err       (done_err),
        .done_head      (done_head),
        .done_n_in      (done_n_in),
        .done_n_out     (done_n_out)
    );
endmodule

// File: tb/vq_chain_fetch_tb.sv
// Self-checking bench: sparse byte memory model with random stalls, a
// bench-side reference walk, directed corners and seeded random rounds.
module vq_chain_fetch_tb_top;
    logic        clk;
    logic        rst_n;
    logic        cfg_wr;
    logic [31:0] cfg_pfn;
    logic [3:0]  cfg_size_log2;
    logic [31:0] q_pfn;
    logic [63:0] q_desc_base, q_avail_base, q_used_base;
    logic [15:0] q_next_avail;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic        cmd_ready;
    logic        mem_req_valid, mem_req_ready;
    logic [63:0] mem_req_addr;
    logic        mem_resp_valid;
    logic [127:0] mem_resp_data;
    logic        seg_valid;
    logic [63:0] seg_addr;
    logic [31:0] seg_len;
    logic        seg_write;
    logic        done_valid, done_ok, done_err;
    logic [15:0] done_head, done_n_in, done_n_out;

    vq_chain_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pfn(cfg_pfn),
        .cfg_size_log2(cfg_size_log2), .q_pfn(q_pfn), .q_desc_base(q_desc_base),
        .q_avail_base(q_avail_base), .q_used_base(q_used_base), .q_next_avail(q_next_avail),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .seg_valid(seg_valid), .seg_addr(seg_addr), .seg_len(seg_len), .seg_write(seg_write),
        .done_valid(done_valid), .done_ok(done_ok), .done_err(done_err), .done_head(done_head),
        .done_n_in(done_n_in), .done_n_out(done_n_out)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int proto_err = 0;

    logic [7:0] mem [longint unsigned];

    function automatic logic [7:0] rd8(longint unsigned a);
        if (mem.exists(a)) return mem[a];
        return 8'h00;
    endfunction
    function automatic logic [127:0] rd128(longint unsigned a);
        logic [127:0] v;
        for (int k = 0; k < 16; k++) v[k*8 +: 8] = rd8(a + longint'(k));
        return v;
    endfunction
    function automatic logic [15:0] rd16(longint unsigned a);
        return {rd8(a + 1), rd8(a)};
    endfunction
    task automatic wrb(longint unsigned a, logic [63:0] v, int n);
        for (int k = 0; k < n; k++) mem[a + longint'(k)] = v[k*8 +: 8];
    endtask

    task automatic chk(string what, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // memory responder: random ready, 0..2 cycle latency, hold-check
    initial begin
        bit pend = 0;
        int wcnt = 0;
        longint unsigned paddr = 0;
        bit pv = 0, pr = 0;
        logic [63:0] pa = 0;
        mem_req_ready = 1'b0; mem_resp_valid = 1'b0; mem_resp_data = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pend = 0; pv = 0; pr = 0; mem_req_ready = 1'b0; mem_resp_valid = 1'b0;
            end else begin
                if (pv && !pr && (!mem_req_valid || mem_req_addr != pa)) proto_err++;
                mem_resp_valid = 1'b0;
                if (pv && pr) begin pend = 1; wcnt = $urandom % 3; paddr = pa; end
                if (pend) begin
                    if (wcnt == 0) begin
                        mem_resp_valid = 1'b1; mem_resp_data = rd128(paddr); pend = 0;
                    end else wcnt--;
                end
                mem_req_ready = (!pend && !mem_resp_valid) ? (($urandom % 4) != 0) : 1'b0;
                pv = mem_req_valid; pr = mem_req_ready; pa = mem_req_addr;
                if (pv && pr && pend) proto_err++;
            end
        end
    end

    // segment monitor
    logic [63:0] g_addr [64];
    logic [31:0] g_len [64];
    logic        g_wr [64];
    int          g_n = 0;
    initial forever begin
        @(negedge clk);
        if (seg_valid && g_n < 64) begin
            g_addr[g_n] = seg_addr; g_len[g_n] = seg_len; g_wr[g_n] = seg_write; g_n++;
        end
    end

    // bench-side model of the queue
    longint unsigned e_pfn = 0;
    int              e_log2 = 0;
    logic [15:0]     e_next = 0;
    bit          x_ok, x_err;
    logic [15:0] x_head, x_in, x_out;
    int          x_n;
    logic [63:0] x_addr [64];
    logic [31:0] x_len [64];
    logic        x_wr [64];
    string       x_tag;

    function automatic longint unsigned dbase();  return e_pfn << 12; endfunction
    function automatic longint unsigned abase();  return dbase() + (longint'(1) << e_log2) * 16; endfunction

    task automatic ref_op(logic [1:0] op);
        int size = 1 << e_log2;
        logic [15:0] g, idx, fl;
        longint unsigned a;
        x_ok = 0; x_err = 0; x_head = 0; x_in = 0; x_out = 0; x_n = 0;
        g = rd16(abase() + 2);
        if (g == e_next) begin x_tag = "R4"; return; end
        if (op == 2'd2) begin x_tag = "R7"; x_ok = 1; e_next++; return; end
        x_tag = (op == 2'd0) ? "R5" : "R6";
        x_head = rd16(abase() + 4 + 2 * longint'(e_next % size));
        if (op == 2'd0) e_next++;
        idx = x_head;
        for (int k = 0; k < size; k++) begin
            a = dbase() + 16 * longint'(idx % size);
            x_addr[x_n] = rd128(a)[63:0];
            x_len[x_n]  = rd128(a)[95:64];
            fl          = rd16(a + 12);
            x_wr[x_n]   = fl[1];
            if (fl[1]) x_in++; else x_out++;
            x_n++;
            if (!fl[0]) begin x_ok = 1; return; end
            idx = rd16(a + 14);
        end
        x_err = 1;
    endtask

    task automatic do_op(logic [1:0] op);
        bit ok, er;
        logic [15:0] hd, ni, no;
        ref_op(op);
        while (!cmd_ready) @(negedge clk);
        g_n = 0;
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done_valid) @(negedge clk);
        ok = done_ok; er = done_err; hd = done_head; ni = done_n_in; no = done_n_out;
        @(negedge clk);
        chk({x_tag, " done_ok"}, ok, x_ok);
        chk({x_tag, " R10 done_err"}, er, x_err);
        chk({x_tag, " head"}, hd, x_head);
        chk({x_tag, " R8 n_in"}, ni, x_in);
        chk({x_tag, " R8 n_out"}, no, x_out);
        chk({x_tag, " R9 segment count"}, g_n, x_n);
        for (int k = 0; k < x_n && k < g_n; k++) begin
            chk("R8 seg_addr", g_addr[k], x_addr[k]);
            chk("R8 seg_len", g_len[k], x_len[k]);
            chk("R8 seg_write", g_wr[k], x_wr[k]);
        end
        chk({x_tag, " next_avail"}, q_next_avail, e_next);
    endtask

    task automatic cfg(longint unsigned pfn, int lg);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_pfn = 32'(pfn); cfg_size_log2 = 4'(lg);
        @(negedge clk);
        cfg_wr = 1'b0;
        e_pfn = pfn; e_log2 = lg; e_next = 0;
    endtask

    task automatic put_desc(int i, logic [63:0] ad, logic [31:0] ln, logic [15:0] fl, logic [15:0] nx);
        longint unsigned a = dbase() + 16 * longint'(i);
        wrb(a, ad, 8); wrb(a + 8, 64'(ln), 4); wrb(a + 12, 64'(fl), 2); wrb(a + 14, 64'(nx), 2);
    endtask
    task automatic put_slot(int s, logic [15:0] v);
        wrb(abase() + 4 + 2 * longint'(s), 64'(v), 2);
    endtask
    task automatic put_gidx(logic [15:0] v);
        wrb(abase() + 2, 64'(v), 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_pfn = '0; cfg_size_log2 = '0;
        cmd_valid = 1'b0; cmd_op = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R3)
        chk("R3 reset cmd_ready", cmd_ready, 1);
        chk("R3 reset desc base", q_desc_base, 0);
        chk("R3 reset used base", q_used_base, 0);
        chk("R3 reset next_avail", q_next_avail, 0);
        chk("R3 reset mem_req_valid", mem_req_valid, 0);
        chk("R3 reset done_valid", done_valid, 0);

        // layout (R1, R2)
        cfg(7, 8);
        chk("R1 desc base 256", q_desc_base, 64'h7000);
        chk("R2 avail base 256", q_avail_base, 64'h8000);
        chk("R2 used base 256", q_used_base, 64'h9000);
        cfg(5, 3);
        chk("R1 desc base", q_desc_base, 64'h5000);
        chk("R2 avail base", q_avail_base, 64'h5080);
        chk("R2 used base", q_used_base, 64'h6000);
        chk("R3 pfn stored", q_pfn, 5);

        // empty (R4)
        put_gidx(16'd0);
        do_op(2'd0);
        // three-descriptor mixed chain: peek then get (R6, R5, R9)
        put_desc(2, 64'h1111_0000_0000_2000, 32'd100, 16'h0001, 16'd5);
        put_desc(5, 64'h2222_0000_0000_3000, 32'd200, 16'h0003, 16'd7);
        put_desc(7, 64'h3333_0000_0000_4000, 32'd300, 16'h0002, 16'd0);
        put_slot(0, 16'd2);
        put_gidx(16'd1);
        do_op(2'd1);
        chk("R6 peek keeps index", q_next_avail, 0);
        do_op(2'd0);
        chk("R5 get advances index", q_next_avail, 1);
        do_op(2'd0);
        // skip (R7)
        put_slot(1, 16'd7); put_slot(2, 16'd26);
        put_gidx(16'd3);
        do_op(2'd2);
        chk("R7 skip emits nothing", g_n, 0);
        // head at or above size wraps (R11): 26 mod 8 = 2
        do_op(2'd3);
        chk("R11 head wrap segment count", g_n, 3);

        // slot index wrap (R11): size 4, five skips then peek slot 1
        cfg(9, 2);
        put_desc(3, 64'hABCD, 32'd64, 16'h0000, 16'd0);
        for (int s = 0; s < 4; s++) put_slot(s, 16'd0);
        put_slot(1, 16'd7);
        put_gidx(16'd6);
        for (int k = 0; k < 5; k++) do_op(2'd2);
        do_op(2'd1);
        chk("R11 wrapped slot head", x_head, 7);
        // self loop cut at ring size (R10)
        put_desc(0, 64'h10, 32'd1, 16'h0003, 16'd4);
        put_slot(1, 16'd0);
        do_op(2'd0);
        chk("R10 loop cut error flag", x_err, 1);

        // seeded random rounds
        for (int r = 0; r < 12; r++) begin
            int lg = $urandom % 5;
            int size = 1 << lg;
            mem.delete();
            cfg(1 + ($urandom % 30), lg);
            for (int i = 0; i < size; i++) begin
                logic [15:0] fl;
                fl = {14'd0, 1'($urandom % 2), 1'((i != size - 1) && ($urandom % 2))};
                put_desc(i, {$urandom, $urandom}, $urandom, fl,
                         16'(i + 1 + size * ($urandom % 3)));
                put_slot(i, 16'(($urandom % size) + size * ($urandom % 4)));
            end
            put_gidx(16'($urandom % (2 * size + 2)));
            for (int k = 0; k < 8; k++) do_op(2'($urandom % 4));
        end

        // clear via page number zero (R3)
        cfg(0, 3);
        chk("R3 clear desc base", q_desc_base, 0);
        chk("R3 clear avail base", q_avail_base, 0);
        chk("R3 clear used base", q_used_base, 0);
        chk("R3 clear pfn", q_pfn, 0);
        chk("R3 clear next_avail", q_next_avail, 0);
        chk("R12 request hold / single outstanding", proto_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule